// File: doc/BRIEF.md
# DMA Channel Graceful-Halt Controller

This block holds the run control of a single DMA channel and guards its configuration registers. Software starts the channel by writing 1 to the run bit of the control register. The same write loads the transfer mode: single, block or burst. Software asks the channel to stop by writing 0 to the run bit.

The channel does not stop at once. It keeps running until the transfer engine reaches a safe stopping point, and that point depends on the mode:

- Single mode stops at the end of the transfer in flight.
- Block mode stops at the end of the current block.
- Burst mode allows at most three more transfer completions.

Until the stopping point the run bit still reads 1. That bit is the only status software needs: it may reprogram the channel once it reads the bit back as 0.

While the run bit is 1, the configuration registers are locked. A write to them is dropped and reported by a one-cycle reject pulse. Address generation and the bus protocol are not part of the block. The transfer engine appears only through its request, active, done and block handshakes. The block answers it with a permission-to-continue signal.

Top module: `dma_halt_ctrl`

## Requirements
- R1: After reset, chan_en, chan_go and wr_reject are 0. Writes to the configuration registers (addresses 1 and 2) are stored and read back unchanged.
- R2: A write to address 0 with bit 0 = 1 while chan_en is 0 sets chan_en. It also loads the mode from bits [2:1] (0 single, 1 block, 2 burst). Address 0 reads back {mode, chan_en} in bits [2:0].
- R3: While chan_en is 1, a write to address 1 or 2 leaves the stored value unchanged. wr_reject is 1 in the cycle after that write and 0 otherwise. Mode bits in an address-0 write are also ignored while chan_en is 1.
- R4: A stop write (address 0, bit 0 = 0) while the engine is idle clears chan_en at the same clock edge. Idle means xfer_active is 0, and in block mode blk_active is also 0.
- R5: In single mode, a stop during an active transfer keeps chan_en at 1 until the cycle in which xfer_done is 1. chan_en clears at that edge.
- R6: In block mode, a stop while blk_active is 1 keeps chan_en at 1 through any number of xfer_done pulses. chan_en clears at the edge where blk_done is 1.
- R7: In burst mode, a stop with xfer_req at 1 keeps chan_en at 1 for at most three more xfer_done pulses. chan_en clears at the edge of the third.
- R8: In burst mode, a pending stop also ends earlier when xfer_req and xfer_active are both 0.
- R9: Writing bit 0 = 1 to address 0 while a stop is pending cancels the stop, and chan_en stays 1 afterwards. This holds even when the write falls in the same cycle as the stopping point.
- R10: chan_go is 0 whenever chan_en is 0. While a stop is pending, chan_go is 0 in single mode, equal to blk_active in block mode, and 1 in burst mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Write address: 0 is control, 1 and up are configuration |
| wr_data | input | DW | Write data |
| rd_addr | input | AW | Read address |
| rd_data | output | DW | Read data, combinational |
| xfer_req | input | 1 | Transfer request still pending at the engine |
| xfer_active | input | 1 | A transfer is in flight |
| xfer_done | input | 1 | The in-flight transfer completes this cycle |
| blk_active | input | 1 | A block is in progress |
| blk_done | input | 1 | The current block ends this cycle |
| chan_en | output | 1 | Run bit as software sees it |
| chan_go | output | 1 | Engine may start or continue transfers |
| wr_reject | output | 1 | One-cycle pulse for a blocked configuration write |

## Verification
Two things can land on the same clock edge: the channel reaching its stopping point, and software writing 1 to cancel the stop. The bench provokes this by raising xfer_done in the very cycle it issues the cancel write to a pending single-mode stop. It passes only if chan_en is still 1 afterwards and a later idle stop still clears it. A second collision is a locked configuration write in the cycle the stopping point is reached. That write must still be rejected, because the lock follows the run bit as it stood when the write arrived.

// File: rtl/dma_halt_pkg.sv
package dma_halt_pkg;

  typedef enum logic [1:0] {
    XM_SINGLE = 2'd0,
    XM_BLOCK  = 2'd1,
    XM_BURST  = 2'd2,
    XM_RSVD   = 2'd3
  } xmode_e;

  localparam int DRAIN_MAX = 3;
  localparam int DRAIN_W   = $clog2(DRAIN_MAX + 1);

  // Engine has nothing in flight that the stop must wait for.
  function automatic logic engine_idle(xmode_e m, logic act, logic blk);
    if (m == XM_BLOCK) return !act && !blk;
    return !act;
  endfunction

  // Safe stopping point for a pending stop, per mode.
  function automatic logic at_boundary(xmode_e m, logic act, logic done,
                                       logic blk, logic blk_end, logic req,
                                       logic [DRAIN_W-1:0] drain);
    case (m)
      XM_BLOCK: return blk ? blk_end : (!act || done);
      XM_BURST: return (done && drain == DRAIN_W'(1)) || (!req && !act);
      default:  return !act || done;
    endcase
  endfunction

endpackage

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
  import dma_halt_pkg::*;
#(
  parameter int DW      = 8,
  parameter int NUM_CFG = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_CFG-1:0]              wr_sel,
  input  logic [DW-1:0]                   wr_data,
  input  logic                            lock,
  output logic [NUM_CFG-1:0][DW-1:0]      cfg_q,
  output logic                            wr_reject
);

  logic any_sel;
  logic wr_blocked;

  assign any_sel    = |wr_sel;
  assign wr_blocked = any_sel && lock;

  for (genvar i = 0; i < NUM_CFG; i++) begin : g_cfg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    cfg_q[i] <= '0;
      else if (wr_sel[i] && !lock)   cfg_q[i] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_reject <= 1'b0;
    else        wr_reject <= wr_blocked;
  end

  // R3
  cfg_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_blocked |=> $stable(cfg_q) && wr_reject);

  // R3
  reject_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_blocked |=> !wr_reject);

endmodule

// File: rtl/dma_halt_core.sv
module dma_halt_core
  import dma_halt_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ctl_wr,
  input  logic                ctl_run,
  input  logic [1:0]          ctl_mode,
  input  logic                xfer_req,
  input  logic                xfer_active,
  input  logic                xfer_done,
  input  logic                blk_active,
  input  logic                blk_done,
  output logic                chan_en,
  output xmode_e              mode,
  output logic                chan_go
);

  logic               en_q, pend_q;
  xmode_e             mode_q;
  logic [DRAIN_W-1:0] drain_q;

  // named internal events
  logic start_ev, stop_ev, cancel_ev, idle_now, boundary_ev, drain_ev;

  assign start_ev    = ctl_wr && ctl_run && !en_q;
  assign stop_ev     = ctl_wr && !ctl_run && en_q && !pend_q;
  assign cancel_ev   = ctl_wr && ctl_run && en_q && pend_q;
  assign idle_now    = engine_idle(mode_q, xfer_active, blk_active);
  assign boundary_ev = pend_q && at_boundary(mode_q, xfer_active, xfer_done,
                                             blk_active, blk_done, xfer_req, drain_q);
  assign drain_ev    = pend_q && (mode_q == XM_BURST) && xfer_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      pend_q  <= 1'b0;
      drain_q <= '0;
      mode_q  <= XM_SINGLE;
    end else if (start_ev) begin
      en_q    <= 1'b1;
      pend_q  <= 1'b0;
      mode_q  <= xmode_e'(ctl_mode);
    end else if (cancel_ev) begin
      pend_q  <= 1'b0;
      drain_q <= '0;
    end else if (stop_ev) begin
      if (idle_now) begin
        en_q    <= 1'b0;
      end else begin
        pend_q  <= 1'b1;
        drain_q <= DRAIN_W'(DRAIN_MAX);
      end
    end else if (boundary_ev) begin
      en_q    <= 1'b0;
      pend_q  <= 1'b0;
      drain_q <= '0;
    end else if (drain_ev) begin
      drain_q <= drain_q - 1'b1;
    end
  end

  always_comb begin
    chan_go = 1'b0;
    if (en_q) begin
      if (!pend_q)                  chan_go = 1'b1;
      else if (mode_q == XM_BURST)  chan_go = 1'b1;
      else if (mode_q == XM_BLOCK)  chan_go = blk_active;
    end
  end

  assign chan_en = en_q;
  assign mode    = mode_q;

  // R4
  idle_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev && idle_now |=> !chan_en);

  // R5
  single_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q && mode_q == XM_SINGLE && xfer_active && !xfer_done && !ctl_wr |=> chan_en);

  // R6
  block_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q && mode_q == XM_BLOCK && blk_active && !blk_done && !ctl_wr |=> chan_en);

  // R7
  drain_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q && mode_q == XM_BURST |-> drain_q != '0);

  // R9
  cancel_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cancel_ev |=> chan_en && !pend_q);

  // R10
  go_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |-> !chan_go);

endmodule

// File: rtl/dma_halt_ctrl.sv
module dma_halt_ctrl
  import dma_halt_pkg::*;
#(
  parameter int DW      = 8,
  parameter int AW      = 2,
  parameter int NUM_CFG = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          xfer_req,
  input  logic          xfer_active,
  input  logic          xfer_done,
  input  logic          blk_active,
  input  logic          blk_done,
  output logic          chan_en,
  output logic          chan_go,
  output logic          wr_reject
);

  localparam int CTL_BITS = 3;

  logic                        ctl_wr;
  logic [NUM_CFG-1:0]          cfg_sel;
  logic [NUM_CFG-1:0][DW-1:0]  cfg_q;
  xmode_e                      mode;

  assign ctl_wr = wr_en && (wr_addr == '0);

  for (genvar i = 0; i < NUM_CFG; i++) begin : g_sel
    assign cfg_sel[i] = wr_en && (wr_addr == AW'(i + 1));
  end

  dma_halt_core u_core (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl_wr      (ctl_wr),
    .ctl_run     (wr_data[0]),
    .ctl_mode    (wr_data[2:1]),
    .xfer_req    (xfer_req),
    .xfer_active (xfer_active),
    .xfer_done   (xfer_done),
    .blk_active  (blk_active),
    .blk_done    (blk_done),
    .chan_en     (chan_en),
    .mode        (mode),
    .chan_go     (chan_go)
  );

  dma_cfg_regs #(.DW(DW), .NUM_CFG(NUM_CFG)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_sel    (cfg_sel),
    .wr_data   (wr_data),
    .lock      (chan_en),
    .cfg_q     (cfg_q),
    .wr_reject (wr_reject)
  );

  always_comb begin
    rd_data = '0;
    if (rd_addr == '0) begin
      rd_data[CTL_BITS-1:0] = {mode, chan_en};
    end else begin
      for (int i = 0; i < NUM_CFG; i++)
        if (rd_addr == AW'(i + 1)) rd_data = cfg_q[i];
    end
  end

  // R2
  mode_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chan_en && $past(chan_en) |-> $stable(mode));

endmodule

// File: tb/sim_dma_halt_ctrl.sv
`timescale 1ns/1ps
module sim_dma_halt_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       xfer_req = 1'b0, xfer_active = 1'b0, xfer_done = 1'b0;
  logic       blk_active = 1'b0, blk_done = 1'b0;
  logic       chan_en, chan_go, wr_reject;

  int errors = 0;
  int checks = 0;
  bit done_flag = 1'b0;

  always #4 clk = ~clk;

  dma_halt_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .xfer_req(xfer_req),
    .xfer_active(xfer_active), .xfer_done(xfer_done), .blk_active(blk_active),
    .blk_done(blk_done), .chan_en(chan_en), .chan_go(chan_go), .wr_reject(wr_reject)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  function automatic logic [7:0] ctl_word(input int m, input logic run);
    return 8'((m << 1) | int'(run));
  endfunction

  task automatic engine_off();
    xfer_req = 0; xfer_active = 0; xfer_done = 0; blk_active = 0; blk_done = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [7:0] cfg_exp [1:2];

    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    chk({5'd0, chan_en, chan_go, wr_reject}, 8'h0, "R1 reset outputs");
    rd(2'd0, v); chk(v, 8'h0, "R1 control readback after reset");
    for (int a = 1; a <= 2; a++) begin
      for (int k = 0; k < 8; k++) begin
        logic [7:0] pat;
        pat = 8'((k * 37 + a * 11) ^ (1 << k));
        wr(2'(a), pat);
        rd(2'(a), v);
        chk(v, pat, "R1 cfg writable");
        cfg_exp[a] = pat;
      end
    end

    // R2/R3/R4 per mode, idle engine
    for (int m = 0; m < 3; m++) begin
      wr(2'd0, ctl_word(m, 1'b1));
      chk({7'd0, chan_en}, 8'd1, "R2 run set");
      rd(2'd0, v); chk(v, ctl_word(m, 1'b1), "R2 mode readback");
      chk({7'd0, chan_go}, 8'd1, "R10 go while running");
      for (int a = 1; a <= 2; a++) begin
        wr(2'(a), ~cfg_exp[a]);
        chk({7'd0, wr_reject}, 8'd1, "R3 reject pulse");
        rd(2'(a), v); chk(v, cfg_exp[a], "R3 cfg unchanged");
        tick();
        chk({7'd0, wr_reject}, 8'd0, "R3 reject one cycle");
      end
      wr(2'd0, ctl_word((m + 1) % 3, 1'b1));
      rd(2'd0, v); chk(v, ctl_word(m, 1'b1), "R3 mode ignored while running");
      wr(2'd0, ctl_word(m, 1'b0));
      chk({7'd0, chan_en, chan_go}, 8'd0, "R4 idle stop clears");
    end

    // R5 single mode, stop during transfer
    wr(2'd0, ctl_word(0, 1'b1));
    xfer_req = 1; xfer_active = 1;
    wr(2'd0, ctl_word(0, 1'b0));
    for (int c = 0; c < 4; c++) begin
      chk({6'd0, chan_en, chan_go}, 8'b10, "R5 hold, R10 go low");
      tick();
    end
    xfer_done = 1; tick(); engine_off();
    chk({7'd0, chan_en}, 8'd0, "R5 clears at done");

    // R6 block mode
    wr(2'd0, ctl_word(1, 1'b1));
    blk_active = 1; xfer_active = 1; xfer_req = 1;
    wr(2'd0, ctl_word(1, 1'b0));
    for (int c = 0; c < 5; c++) begin
      xfer_done = 1; tick(); xfer_done = 0;
      chk({6'd0, chan_en, chan_go}, 8'b11, "R6 hold through block, R10 go");
    end
    // locked write in the same cycle as the boundary
    blk_done = 1;
    wr(2'd1, ~cfg_exp[1]);
    engine_off();
    chk({6'd0, chan_en, wr_reject}, 8'b01, "R6 clears at blk_done, R3 still rejected");
    rd(2'd1, v); chk(v, cfg_exp[1], "R3 cfg unchanged at boundary");

    // R7/R8 burst sweep: k completions before the request drops
    for (int k = 0; k <= 3; k++) begin
      wr(2'd0, ctl_word(2, 1'b1));
      xfer_req = 1; xfer_active = 1;
      wr(2'd0, ctl_word(2, 1'b0));
      for (int i = 0; i < k; i++) begin
        xfer_done = 1; tick(); xfer_done = 0;
        if (i < 2) chk({6'd0, chan_en, chan_go}, 8'b11, "R7 burst draining");
        else       chk({7'd0, chan_en}, 8'd0, "R7 clears after third");
      end
      if (k < 3) begin
        tick();
        chk({7'd0, chan_en}, 8'd1, "R8 still running with request");
        xfer_req = 0; xfer_active = 0; tick();
        chk({7'd0, chan_en}, 8'd0, "R8 early end on request drop");
      end
      engine_off();
    end

    // R9 cancel, then transfer end must not halt
    wr(2'd0, ctl_word(0, 1'b1));
    xfer_active = 1;
    wr(2'd0, ctl_word(0, 1'b0));
    wr(2'd0, ctl_word(0, 1'b1));
    xfer_done = 1; tick(); engine_off(); tick();
    chk({6'd0, chan_en, chan_go}, 8'b11, "R9 cancel keeps running");
    wr(2'd0, ctl_word(0, 1'b0));
    chk({7'd0, chan_en}, 8'd0, "R9 later idle stop");

    // R9 cancel in same cycle as boundary
    wr(2'd0, ctl_word(0, 1'b1));
    xfer_active = 1;
    wr(2'd0, ctl_word(0, 1'b0));
    xfer_done = 1;
    wr(2'd0, ctl_word(0, 1'b1));
    engine_off(); tick();
    chk({7'd0, chan_en}, 8'd1, "R9 cancel wins over boundary");
    wr(2'd0, ctl_word(0, 1'b0));
    chk({7'd0, chan_en}, 8'd0, "R9 stop after collision");

    done_flag = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule